// File: doc/BRIEF.md
# Fast-Path / Microcode Dispatch Splitter

This block sits between an instruction pre-decoder and the integer and floating-point schedulers. Each cycle it looks at a small in-order window of pre-decoded instructions. Each instruction carries the number of fixed-length micro-ops it expands to, a small opcode class and a tag. Short instructions, of one or two ops, are expanded directly. Their ops are packed into a three-slot dispatch bundle, and several instructions can share one bundle. A longer instruction is handed to a microcode sequencer. The sequencer looks up a ROM start address from the instruction's class. It then walks the ROM, emitting up to three ops per cycle, until it reaches an entry flagged as the last of its sequence.

Both paths drive the same registered three-wide dispatch port. Program order is kept in three ways. The window is consumed strictly from lane 0 upward. No short instruction is accepted while a microcode sequence is running. An instruction is never split across two bundles. A stall input from the schedulers freezes the whole block.

Top module: `dsp_split`

## Requirements
- R1: An instruction whose op count is 1 or 2 is expanded in place. Its ops occupy consecutive slots, each with kind 0, the instruction's tag, and info equal to the op's index (0, then 1).
- R2: An instruction whose op count is above 2 is accepted and puts no op into the bundle of the cycle it is accepted in. Its microcode ops (kind 1, carrying its tag) start in the following bundle.
- R3: Accepted short instructions fill the lowest free slots in lane order, at most 3 ops per bundle. The valid slots always form a contiguous run starting at slot 0. `instr_ready_o[k]` high means lane k is consumed this cycle, and the set of consumed lanes is always a prefix of the window.
- R4: A short instruction whose ops do not fit in the slots left in the current bundle is not consumed, and no later lane is consumed. It is offered whole in a later cycle and is never split.
- R5: The microcode start address for class c is 8·c. Each microcode op carries its ROM address in the info field.
- R6: The sequence for class c is c+3 ops long: its end flag sits at address 8·c+c+2. Up to 3 ROM ops are emitted per bundle, and the slots after the flagged op are empty.
- R7: In the cycle after the bundle holding the flagged op is issued, short instructions are consumed again.
- R8: While a microcode sequence is running, no lane is consumed. A long instruction also stops the consumption of every lane after it in the same cycle.
- R9: While `stall_i` is high, no lane is consumed, the dispatch outputs keep their values, and the microcode sequencer does not advance.
- R10: After reset all slots are empty and the block is in fast-path mode.
- R11: A lane whose valid bit is low stops consumption of all later lanes in that cycle, and a cycle with nothing consumed in fast-path mode issues an empty bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Scheduler back-pressure; freezes the block |
| instr_valid_i | input | LANES | Per-lane instruction present |
| instr_nops_i | input | LANES×CNT_W | Per-lane micro-op count |
| instr_cls_i | input | LANES×CLS_W | Per-lane opcode class (microcode start) |
| instr_tag_i | input | LANES×TAG_W | Per-lane instruction tag |
| instr_ready_o | output | LANES | Per-lane consumed this cycle |
| slot_vld_o | output | SLOTS | Dispatch slot valid |
| slot_kind_o | output | SLOTS | 0 = fast-path op, 1 = microcode op |
| slot_tag_o | output | SLOTS×TAG_W | Tag of the owning instruction |
| slot_info_o | output | SLOTS×UADDR_W | Op index (fast) or ROM address (microcode) |

## Verification
The bench builds the block with its default configuration: three window lanes, three slots, four classes and a 32-entry ROM. In this configuration every combination of op counts 1–3 over the three lanes can be swept under every lane-valid mask. That sweep reaches each packing, refusal and blocking case, and each of the four microcode sequence lengths from several entry patterns. Directed stall passes then freeze both a fast bundle and a running sequence part-way through.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic {OP_FAST = 1'b0, OP_UCODE = 1'b1} op_kind_e;
  localparam int FAST_MAX = 2;  // longest op count handled without microcode
endpackage

// File: rtl/dsp_rom.sv
module dsp_rom #(
  parameter int CLS_W   = 2,
  parameter int UADDR_W = 5,
  parameter int SLOTS   = 3
) (
  input  logic [CLS_W-1:0]                cls_i,
  output logic [UADDR_W-1:0]              entry_o,
  input  logic [UADDR_W-1:0]              base_i,
  output logic [SLOTS-1:0][UADDR_W-1:0]   addr_o,
  output logic [SLOTS-1:0]                end_o
);
  import dsp_pkg::*;

  localparam int OFF_W = UADDR_W - CLS_W;
  localparam int DEPTH = 1 << UADDR_W;
  localparam int NCLS  = 1 << CLS_W;

  logic [DEPTH-1:0]              end_tbl;
  logic [NCLS-1:0][UADDR_W-1:0]  entry_tbl;

  // class c owns a 2^OFF_W window; its sequence is c+FAST_MAX+1 ops long
  for (genvar a = 0; a < DEPTH; a++) begin : g_end
    localparam int OFF = a % (1 << OFF_W);
    localparam int SEQ = a >> OFF_W;
    assign end_tbl[a] = (OFF == SEQ + FAST_MAX) ? 1'b1 : 1'b0;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_entry
    assign entry_tbl[c] = UADDR_W'(c << OFF_W);
  end

  assign entry_o = entry_tbl[cls_i];

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    assign addr_o[s] = base_i + UADDR_W'(s);
    assign end_o[s]  = end_tbl[addr_o[s]];
  end
endmodule

// File: rtl/dsp_fast_pack.sv
module dsp_fast_pack #(
  parameter int LANES  = 3,
  parameter int SLOTS  = 3,
  parameter int CNT_W  = 3,
  parameter int CLS_W  = 2,
  parameter int TAG_W  = 8,
  parameter int INFO_W = 5
) (
  input  logic                          en_i,
  input  logic [LANES-1:0]              vld_i,
  input  logic [LANES-1:0][CNT_W-1:0]   nops_i,
  input  logic [LANES-1:0][CLS_W-1:0]   cls_i,
  input  logic [LANES-1:0][TAG_W-1:0]   tag_i,
  output logic [LANES-1:0]              acc_o,
  output logic [SLOTS-1:0]              slot_vld_o,
  output logic [SLOTS-1:0][TAG_W-1:0]   slot_tag_o,
  output logic [SLOTS-1:0][INFO_W-1:0]  slot_idx_o,
  output logic                          ustart_o,
  output logic [CLS_W-1:0]              ucls_o,
  output logic [TAG_W-1:0]              utag_o
);
  import dsp_pkg::*;

  always_comb begin
    int   used;
    logic go;
    used       = 0;
    go         = 1'b1;
    acc_o      = '0;
    slot_vld_o = '0;
    slot_tag_o = '0;
    slot_idx_o = '0;
    ustart_o   = 1'b0;
    ucls_o     = '0;
    utag_o     = '0;
    for (int k = 0; k < LANES; k++) begin
      if (go && en_i && vld_i[k]) begin
        if (int'(nops_i[k]) <= FAST_MAX) begin
          if (used + int'(nops_i[k]) <= SLOTS) begin
            for (int j = 0; j < FAST_MAX; j++) begin
              if (j < int'(nops_i[k]) && (used + j) < SLOTS) begin
                slot_vld_o[used+j] = 1'b1;
                slot_tag_o[used+j] = tag_i[k];
                slot_idx_o[used+j] = INFO_W'(j);
              end
            end
            used     = used + int'(nops_i[k]);
            acc_o[k] = 1'b1;
          end else begin
            go = 1'b0;  // never split an instruction across bundles
          end
        end else begin
          acc_o[k] = 1'b1;
          ustart_o = 1'b1;
          ucls_o   = cls_i[k];
          utag_o   = tag_i[k];
          go       = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsp_useq.sv
module dsp_useq #(
  parameter int CLS_W   = 2,
  parameter int UADDR_W = 5,
  parameter int TAG_W   = 8,
  parameter int SLOTS   = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          stall_i,
  input  logic                          start_i,
  input  logic [CLS_W-1:0]              start_cls_i,
  input  logic [TAG_W-1:0]              start_tag_i,
  output logic                          busy_o,
  output logic [SLOTS-1:0]              vld_o,
  output logic [SLOTS-1:0][UADDR_W-1:0] addr_o,
  output logic [TAG_W-1:0]              tag_o
);
  logic                 busy_q;
  logic [UADDR_W-1:0]   upc_q;
  logic [TAG_W-1:0]     tag_q;
  logic [UADDR_W-1:0]   entry;
  logic [SLOTS-1:0]     rd_end;
  logic                 fin;

  dsp_rom #(.CLS_W(CLS_W), .UADDR_W(UADDR_W), .SLOTS(SLOTS)) u_rom (
    .cls_i   (start_cls_i),
    .entry_o (entry),
    .base_i  (upc_q),
    .addr_o  (addr_o),
    .end_o   (rd_end)
  );

  always_comb begin
    fin   = 1'b0;
    vld_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      vld_o[s] = busy_q && !fin;
      if (vld_o[s] && rd_end[s]) fin = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      upc_q  <= '0;
      tag_q  <= '0;
    end else if (!stall_i) begin
      if (busy_q) begin
        upc_q <= upc_q + UADDR_W'(SLOTS);
        if (fin) busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        upc_q  <= entry;
        tag_q  <= start_tag_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign tag_o  = tag_q;
endmodule

// File: rtl/dsp_split.sv
module dsp_split #(
  parameter int LANES   = 3,
  parameter int SLOTS   = 3,
  parameter int CNT_W   = 3,
  parameter int CLS_W   = 2,
  parameter int UADDR_W = 5,
  parameter int TAG_W   = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          stall_i,
  input  logic [LANES-1:0]              instr_valid_i,
  input  logic [LANES-1:0][CNT_W-1:0]   instr_nops_i,
  input  logic [LANES-1:0][CLS_W-1:0]   instr_cls_i,
  input  logic [LANES-1:0][TAG_W-1:0]   instr_tag_i,
  output logic [LANES-1:0]              instr_ready_o,
  output logic [SLOTS-1:0]              slot_vld_o,
  output logic [SLOTS-1:0]              slot_kind_o,
  output logic [SLOTS-1:0][TAG_W-1:0]   slot_tag_o,
  output logic [SLOTS-1:0][UADDR_W-1:0] slot_info_o
);
  import dsp_pkg::*;

  localparam int INFO_W = UADDR_W;

  logic                          seq_busy;
  logic                          pack_en;
  logic [SLOTS-1:0]              p_vld;
  logic [SLOTS-1:0][TAG_W-1:0]   p_tag;
  logic [SLOTS-1:0][INFO_W-1:0]  p_idx;
  logic                          p_ustart;
  logic [CLS_W-1:0]              p_ucls;
  logic [TAG_W-1:0]              p_utag;
  logic [SLOTS-1:0]              u_vld;
  logic [SLOTS-1:0][INFO_W-1:0]  u_addr;
  logic [TAG_W-1:0]              u_tag;

  logic [SLOTS-1:0]              nxt_vld, nxt_kind;
  logic [SLOTS-1:0][TAG_W-1:0]   nxt_tag;
  logic [SLOTS-1:0][INFO_W-1:0]  nxt_info;
  logic [SLOTS-1:0]              vld_q, kind_q;
  logic [SLOTS-1:0][TAG_W-1:0]   tag_q;
  logic [SLOTS-1:0][INFO_W-1:0]  info_q;

  assign pack_en = !seq_busy && !stall_i;

  dsp_fast_pack #(
    .LANES(LANES), .SLOTS(SLOTS), .CNT_W(CNT_W),
    .CLS_W(CLS_W), .TAG_W(TAG_W), .INFO_W(INFO_W)
  ) u_pack (
    .en_i       (pack_en),
    .vld_i      (instr_valid_i),
    .nops_i     (instr_nops_i),
    .cls_i      (instr_cls_i),
    .tag_i      (instr_tag_i),
    .acc_o      (instr_ready_o),
    .slot_vld_o (p_vld),
    .slot_tag_o (p_tag),
    .slot_idx_o (p_idx),
    .ustart_o   (p_ustart),
    .ucls_o     (p_ucls),
    .utag_o     (p_utag)
  );

  dsp_useq #(
    .CLS_W(CLS_W), .UADDR_W(UADDR_W), .TAG_W(TAG_W), .SLOTS(SLOTS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .start_i     (p_ustart),
    .start_cls_i (p_ucls),
    .start_tag_i (p_utag),
    .busy_o      (seq_busy),
    .vld_o       (u_vld),
    .addr_o      (u_addr),
    .tag_o       (u_tag)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_mux
    assign nxt_vld[s]  = seq_busy ? u_vld[s] : p_vld[s];
    assign nxt_kind[s] = seq_busy ? OP_UCODE : OP_FAST;
    assign nxt_tag[s]  = seq_busy ? u_tag : p_tag[s];
    assign nxt_info[s] = seq_busy ? u_addr[s] : p_idx[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      kind_q <= '0;
      tag_q  <= '0;
      info_q <= '0;
    end else if (!stall_i) begin
      vld_q  <= nxt_vld;
      kind_q <= nxt_kind;
      tag_q  <= nxt_tag;
      info_q <= nxt_info;
    end
  end

  assign slot_vld_o  = vld_q;
  assign slot_kind_o = kind_q;
  assign slot_tag_o  = tag_q;
  assign slot_info_o = info_q;
endmodule

// File: rtl/dsp_split_chk.sv
module dsp_split_chk #(
  parameter int LANES   = 3,
  parameter int SLOTS   = 3,
  parameter int CNT_W   = 3,
  parameter int UADDR_W = 5,
  parameter int TAG_W   = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          stall_i,
  input logic                          busy_i,
  input logic [LANES-1:0]              instr_valid_i,
  input logic [LANES-1:0][CNT_W-1:0]   instr_nops_i,
  input logic [LANES-1:0]              instr_ready_o,
  input logic [SLOTS-1:0]              slot_vld_o,
  input logic [SLOTS-1:0]              slot_kind_o,
  input logic [SLOTS-1:0][TAG_W-1:0]   slot_tag_o,
  input logic [SLOTS-1:0][UADDR_W-1:0] slot_info_o
);
  import dsp_pkg::*;

  logic [SLOTS-1:0] vld_inc;
  logic             long_acc;

  assign vld_inc = slot_vld_o + SLOTS'(1);

  always_comb begin
    long_acc = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (instr_ready_o[k] && int'(instr_nops_i[k]) > FAST_MAX) long_acc = 1'b1;
  end

  a_r9_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(slot_vld_o) && $stable(slot_kind_o)
                && $stable(slot_tag_o) && $stable(slot_info_o));

  a_r9_stall_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> instr_ready_o == '0);

  a_r8_busy_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> instr_ready_o == '0);

  a_r2_ucode_enters_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_acc |=> busy_i);

  a_r3_slots_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vld_inc));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    a_r11_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      instr_ready_o[k] |-> instr_valid_i[k]);
    if (k > 0) begin : g_pfx
      a_r3_ready_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
        instr_ready_o[k] |-> instr_ready_o[k-1]);
    end
  end
endmodule

bind dsp_split dsp_split_chk #(
  .LANES(LANES), .SLOTS(SLOTS), .CNT_W(CNT_W), .UADDR_W(UADDR_W), .TAG_W(TAG_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stall_i       (stall_i),
  .busy_i        (seq_busy),
  .instr_valid_i (instr_valid_i),
  .instr_nops_i  (instr_nops_i),
  .instr_ready_o (instr_ready_o),
  .slot_vld_o    (slot_vld_o),
  .slot_kind_o   (slot_kind_o),
  .slot_tag_o    (slot_tag_o),
  .slot_info_o   (slot_info_o)
);

// File: tb/dsp_split_bench.sv
`timescale 1ns/1ps
module dsp_split_bench;
  localparam int LANES = 3, SLOTS = 3, CNT_W = 3, CLS_W = 2, UADDR_W = 5, TAG_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stall_i = 1'b0;
  logic [LANES-1:0]              instr_valid_i = '0;
  logic [LANES-1:0][CNT_W-1:0]   instr_nops_i = '0;
  logic [LANES-1:0][CLS_W-1:0]   instr_cls_i = '0;
  logic [LANES-1:0][TAG_W-1:0]   instr_tag_i = '0;
  logic [LANES-1:0]              instr_ready_o;
  logic [SLOTS-1:0]              slot_vld_o;
  logic [SLOTS-1:0]              slot_kind_o;
  logic [SLOTS-1:0][TAG_W-1:0]   slot_tag_o;
  logic [SLOTS-1:0][UADDR_W-1:0] slot_info_o;

  always #2.5 clk = ~clk;

  dsp_split u_dsp_split (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall_i),
    .instr_valid_i(instr_valid_i), .instr_nops_i(instr_nops_i),
    .instr_cls_i(instr_cls_i), .instr_tag_i(instr_tag_i),
    .instr_ready_o(instr_ready_o), .slot_vld_o(slot_vld_o),
    .slot_kind_o(slot_kind_o), .slot_tag_o(slot_tag_o), .slot_info_o(slot_info_o)
  );

  int n_chk = 0, n_bad = 0;
  bit ev[SLOTS];
  int ek[SLOTS], et[SLOTS], ei[SLOTS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_exp();
    for (int s = 0; s < SLOTS; s++) begin ev[s] = 0; ek[s] = 0; et[s] = 0; ei[s] = 0; end
  endtask

  task automatic chk_slots(input string req);
    for (int s = 0; s < SLOTS; s++) begin
      chk(slot_vld_o[s] == ev[s], req, int'(slot_vld_o[s]), int'(ev[s]));
      if (ev[s]) begin
        int act, exp;
        act = (int'(slot_kind_o[s]) << 16) | (int'(slot_tag_o[s]) << 8) | int'(slot_info_o[s]);
        exp = (ek[s] << 16) | (et[s] << 8) | ei[s];
        chk(act == exp, req, act, exp);
      end
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  // microcode drain: checks bundles of class c, tag t, with a short instruction waiting
  task automatic drain_ucode(input int c, input int t);
    int len, base, ncyc;
    len = c + 3; base = 8 * c; ncyc = (len + 2) / 3;
    instr_valid_i = 3'b001; instr_nops_i[0] = 3'd1; instr_tag_i[0] = 8'hEE;
    for (int cy = 0; cy < ncyc; cy++) begin
      #1 chk(instr_ready_o == 3'b000, "R8", int'(instr_ready_o), 0);
      @(negedge clk);
      clr_exp();
      for (int s = 0; s < SLOTS; s++) begin
        int j;
        j = cy * 3 + s;
        if (j < len) begin ev[s] = 1; ek[s] = 1; et[s] = t; ei[s] = base + j; end
      end
      chk_slots("R5 R6");
    end
    #1 chk(instr_ready_o == 3'b001, "R7", int'(instr_ready_o), 1);
    @(negedge clk);
    clr_exp(); ev[0] = 1; ek[0] = 0; et[0] = 8'hEE; ei[0] = 0;
    chk_slots("R7");
    instr_valid_i = '0;
  endtask

  initial begin
    int id;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    clr_exp();
    chk_slots("R10");
    instr_valid_i = 3'b001; instr_nops_i[0] = 3'd2; instr_tag_i[0] = 8'h05;
    #1 chk(instr_ready_o == 3'b001, "R10", int'(instr_ready_o), 1);
    @(negedge clk);
    clr_exp(); ev[0] = 1; et[0] = 5; ev[1] = 1; et[1] = 5; ei[1] = 1;
    chk_slots("R10 R1");
    instr_valid_i = '0;
    @(negedge clk);
    clr_exp(); chk_slots("R11");

    id = 0;
    for (int m = 1; m < 8; m++)
      for (int a = 1; a <= 3; a++)
        for (int b = 1; b <= 3; b++)
          for (int c = 1; c <= 3; c++) begin
            int n[3], used, ucls, utag;
            bit go, ust;
            logic [2:0] acc;
            n[0] = a; n[1] = b; n[2] = c;
            for (int k = 0; k < 3; k++) begin
              instr_nops_i[k] = CNT_W'(n[k]);
              instr_cls_i[k]  = CLS_W'((id + k) % 4);
              instr_tag_i[k]  = TAG_W'((id * 3 + k) & 255);
            end
            instr_valid_i = 3'(m);
            clr_exp(); go = 1; used = 0; acc = '0; ust = 0; ucls = 0; utag = 0;
            for (int k = 0; k < 3; k++) begin
              if (go && m[k]) begin
                if (n[k] <= 2) begin
                  if (used + n[k] <= 3) begin
                    for (int j = 0; j < n[k]; j++) begin
                      ev[used+j] = 1; ek[used+j] = 0;
                      et[used+j] = (id * 3 + k) & 255; ei[used+j] = j;
                    end
                    used += n[k]; acc[k] = 1'b1;
                  end else go = 0;
                end else begin
                  acc[k] = 1'b1; ust = 1; ucls = (id + k) % 4;
                  utag = (id * 3 + k) & 255; go = 0;
                end
              end else go = 0;
            end
            #1 chk(instr_ready_o == acc, "R3 R4 R8 R11", int'(instr_ready_o), int'(acc));
            @(negedge clk);
            chk_slots("R1 R2 R3");
            if (ust) drain_ucode(ucls, utag);
            else begin
              instr_valid_i = '0;
              @(negedge clk);
              clr_exp(); chk_slots("R11");
            end
            id++;
          end

    // stall over a fast bundle
    instr_valid_i = 3'b011;
    instr_nops_i[0] = 3'd2; instr_tag_i[0] = 8'h11;
    instr_nops_i[1] = 3'd1; instr_tag_i[1] = 8'h22;
    @(negedge clk);
    clr_exp();
    ev[0] = 1; et[0] = 8'h11; ev[1] = 1; et[1] = 8'h11; ei[1] = 1; ev[2] = 1; et[2] = 8'h22;
    chk_slots("R1 R3");
    stall_i = 1'b1; instr_valid_i = 3'b001; instr_nops_i[0] = 3'd1; instr_tag_i[0] = 8'h44;
    for (int i = 0; i < 2; i++) begin
      #1 chk(instr_ready_o == 3'b000, "R9", int'(instr_ready_o), 0);
      @(negedge clk);
      chk_slots("R9");
    end
    stall_i = 1'b0;
    #1 chk(instr_ready_o == 3'b001, "R9", int'(instr_ready_o), 1);
    @(negedge clk);
    clr_exp(); ev[0] = 1; et[0] = 8'h44; chk_slots("R9");

    // stall in the middle of a class-3 sequence
    instr_valid_i = 3'b001; instr_nops_i[0] = 3'd5; instr_cls_i[0] = 2'd3; instr_tag_i[0] = 8'h33;
    @(negedge clk);
    instr_valid_i = '0;
    clr_exp(); chk_slots("R2");
    @(negedge clk);
    clr_exp();
    for (int s = 0; s < 3; s++) begin ev[s] = 1; ek[s] = 1; et[s] = 8'h33; ei[s] = 24 + s; end
    chk_slots("R5");
    stall_i = 1'b1;
    @(negedge clk);
    chk_slots("R9");
    stall_i = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 3; s++) ei[s] = 27 + s;
    chk_slots("R9 R6");
    @(negedge clk);
    clr_exp(); chk_slots("R7");

    finish_run();
  end
endmodule